// File: doc/BRIEF.md
# Indirect Codec Register Access Bridge

This bridge places a bank of 8-bit codec control registers behind two 32-bit host registers. The host never addresses the bank directly. It writes a command word into the command register. That word holds a 7-bit internal address, a data byte and a write-request flag.

When the flag is set, the bridge starts an internal write and holds the flag high until the write has finished. When the flag is clear, the command is a read request. The addressed byte then shows up in the data-out register a fixed number of clock cycles later, and the data-out register also carries the live codec interrupt line.

The bank comes out of reset with a fixed default byte in every slot. Slot 0 is a read-only status byte. Slots 5 and 28, and every address at or above the bank size, hold no register. Software polls the busy flag before each access and waits out the read latency before it samples data-out.

Top module: `codec_reg_bridge`

## Requirements
- R1: After reset, reading each bank address returns its default byte: address 0 = 0x00, 1 = 0xC3, 3 = 0x90, 16 = 0xFF, 20 = 0x06, 21 = 0x06, 31 = 0x34.
- R2: Host offset 0x00 is the command register and offset 0x04 is data-out. Reading the command register returns the last accepted command, with the busy flag in bit 16, the address in bits 14:8 and the data byte in bits 7:0. Data-out carries the fetched byte in bits 7:0.
- R3: A command with bit 16 set starts a write. Bit 16 of the command register then reads 1 for exactly WR_CYCLES clock cycles (default 4) after the accepting edge, clears by itself, and the new byte is readable afterwards.
- R4: A command with bit 16 clear starts a read. Data-out bits 7:0 keep their previous value for RD_LAT-1 cycles and take the addressed byte on the RD_LAT-th edge after the accepting edge (default RD_LAT = 6).
- R5: Data-out bit 8 follows the codec interrupt input.
- R6: Address 0 is read-only. A write to it completes its busy period, but the stored byte stays 0x00.
- R7: Addresses 5, 28, any address at or above NUM_REGS, and any command with a reserved bit (15 or 31:17) set reach no register. A write to one of these is discarded, and a read of one returns 0x00.
- R8: A command-register write while bit 16 is set is dropped. The pending write completes with its original address and data, and the command readback is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_off | input | 3 | Host byte offset (0x00 command, 0x04 data-out) |
| host_wdata | input | 32 | Host write data |
| irq_in | input | 1 | Codec interrupt request line |
| host_rdata | output | 32 | Host read data for the current offset |

## Verification
A miscounted operation counter shows up at the ports in two ways. On writes, the busy flag reads high for more or fewer than four cycles after the command. On reads, data-out changes one cycle early or late. Both are visible within ten cycles of the command.

A broken address guard shows up on the next read of that slot, which returns a written byte where 0x00 or the default is due. A command that slips through while the bridge is busy changes the command readback within one cycle. It also leaves the wrong byte in the second register when that register is read back.

// File: rtl/codec_reg_bridge.sv
module codec_reg_bridge #(
  parameter int ADDR_W    = 7,
  parameter int NUM_REGS  = 36,
  parameter int WR_CYCLES = 4,
  parameter int RD_LAT    = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [2:0]  host_off,
  input  logic [31:0] host_wdata,
  input  logic        irq_in,
  output logic [31:0] host_rdata
);
  localparam int MAXC  = (WR_CYCLES > RD_LAT) ? WR_CYCLES : RD_LAT;
  localparam int CNT_W = $clog2(MAXC + 1);

  function automatic logic [7:0] reg_default(input int idx);
    case (idx)
      1, 2:             return 8'hC3;
      3, 6:             return 8'h90;
      4:                return 8'h98;
      5, 16, 28:        return 8'hFF;
      7:                return 8'hB1;
      8:                return 8'h11;
      9:                return 8'h10;
      11:               return 8'h03;
      14:               return 8'h40;
      18, 19, 20, 21:   return 8'h06;
      31:               return 8'h34;
      32:               return 8'h07;
      33:               return 8'h44;
      34:               return 8'h1F;
      default:          return 8'h00;
    endcase
  endfunction

  logic [7:0]        bank [NUM_REGS];
  logic [ADDR_W-1:0] cmd_addr;
  logic [7:0]        cmd_data, dout_q, sel_byte;
  logic              cmd_resv, busy, rd_pend;
  logic [CNT_W-1:0]  cnt;

  wire cmd_we  = host_wr && (host_off == 3'h0);
  wire accept  = cmd_we && !busy;
  wire last    = (cnt == CNT_W'(1));
  wire present = !cmd_resv && (int'(cmd_addr) < NUM_REGS) &&
                 (cmd_addr != ADDR_W'(5)) && (cmd_addr != ADDR_W'(28));
  wire writable = present && (cmd_addr != '0);
  wire commit   = busy && last && writable;

  always_comb begin
    sel_byte = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (present && int'(cmd_addr) == i) sel_byte = bank[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_addr <= '0;
      cmd_data <= '0;
      cmd_resv <= 1'b0;
      busy     <= 1'b0;
      rd_pend  <= 1'b0;
      cnt      <= '0;
      dout_q   <= '0;
    end else if (accept) begin
      cmd_addr <= host_wdata[8 +: ADDR_W];
      cmd_data <= host_wdata[7:0];
      cmd_resv <= host_wdata[15] || (|host_wdata[31:17]);
      busy     <= host_wdata[16];
      rd_pend  <= !host_wdata[16];
      cnt      <= host_wdata[16] ? CNT_W'(WR_CYCLES) : CNT_W'(RD_LAT);
    end else if (busy || rd_pend) begin
      if (last) begin
        busy    <= 1'b0;
        rd_pend <= 1'b0;
        if (rd_pend) dout_q <= sel_byte;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) bank[i] <= reg_default(i);
    end else begin
      for (int i = 0; i < NUM_REGS; i++)
        if (commit && int'(cmd_addr) == i) bank[i] <= cmd_data;
    end
  end

  always_comb begin
    host_rdata = '0;
    if (host_off == 3'h0) begin
      host_rdata[16]            = busy;
      host_rdata[8 +: ADDR_W]   = cmd_addr;
      host_rdata[7:0]           = cmd_data;
    end else if (host_off == 3'h4) begin
      host_rdata[8]   = irq_in;
      host_rdata[7:0] = dout_q;
    end
  end
endmodule

module codec_reg_bridge_chk #(
  parameter int ADDR_W    = 7,
  parameter int NUM_REGS  = 36,
  parameter int WR_CYCLES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              rd_pend,
  input logic              last,
  input logic              cmd_we,
  input logic              cmd_resv,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [7:0]        cmd_data,
  input logic [7:0]        dout_q,
  input logic [7:0]        status_q
);
  localparam int RW = $clog2(WR_CYCLES + 2);
  logic [RW-1:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= '0;
    else if (!busy) busy_run <= '0;
    else if (int'(busy_run) <= WR_CYCLES) busy_run <= busy_run + RW'(1);
  end

  wire hole = cmd_resv || (int'(cmd_addr) >= NUM_REGS) ||
              (cmd_addr == ADDR_W'(5)) || (cmd_addr == ADDR_W'(28));

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    int'(busy_run) <= WR_CYCLES); // R3
  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, rd_pend})); // R3
  AST_DROP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_we) |=> ($stable(cmd_addr) && $stable(cmd_data))); // R8
  AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(status_q)); // R6
  AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend && last && hole) |=> (dout_q == 8'h00)); // R7
  AST_DOUT_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout_q) |-> $past(rd_pend && last)); // R4
endmodule

bind codec_reg_bridge codec_reg_bridge_chk #(
  .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rd_pend(rd_pend), .last(last),
  .cmd_we(cmd_we), .cmd_resv(cmd_resv), .cmd_addr(cmd_addr),
  .cmd_data(cmd_data), .dout_q(dout_q), .status_q(bank[0])
);

// File: tb/codec_reg_bridge_bench.sv
module codec_reg_bridge_bench;
  localparam int RD_LAT = 6;
  localparam int WR_CYCLES = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [2:0]  host_off = 3'h0;
  logic [31:0] host_wdata = '0;
  logic        irq_in = 1'b0;
  logic [31:0] host_rdata;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  codec_reg_bridge u_codec_reg_bridge (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_off(host_off),
    .host_wdata(host_wdata), .irq_in(irq_in), .host_rdata(host_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic peek(input logic [2:0] off, output logic [31:0] v);
    host_off = off;
    #1;
    v = host_rdata;
  endtask

  task automatic cmd(input logic [31:0] w);
    @(negedge clk);
    host_off = 3'h0; host_wdata = w; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] v;
    n = 0;
    for (int k = 0; k < 20; k++) begin
      peek(3'h0, v);
      if (!v[16]) break;
      n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] wr_word(input logic [6:0] a, input logic [7:0] d);
    return {15'b0, 1'b1, 1'b0, a, d};
  endfunction

  task automatic rd_byte(input logic [6:0] a, output logic [7:0] b);
    logic [31:0] v;
    cmd({15'b0, 1'b0, 1'b0, a, 8'h00});
    repeat (RD_LAT) @(negedge clk);
    peek(3'h4, v);
    b = v[7:0];
  endtask

  task automatic t_reset;
    logic [31:0] v; logic [7:0] b;
    peek(3'h0, v); check("R2 cmd reset", v, 32'h0);
    peek(3'h4, v); check("R2 dout reset", v, 32'h0);
    rd_byte(7'd0, b);  check("R1 addr0", {24'b0, b}, 32'h00);
    rd_byte(7'd1, b);  check("R1 addr1", {24'b0, b}, 32'hC3);
    rd_byte(7'd3, b);  check("R1 addr3", {24'b0, b}, 32'h90);
    rd_byte(7'd16, b); check("R1 addr16", {24'b0, b}, 32'hFF);
    rd_byte(7'd31, b); check("R1 addr31", {24'b0, b}, 32'h34);
  endtask

  task automatic t_read_latency;
    logic [31:0] v;
    cmd({15'b0, 1'b0, 1'b0, 7'd3, 8'h00});
    repeat (RD_LAT - 1) @(negedge clk);
    peek(3'h4, v); check("R4 old value held", {24'b0, v[7:0]}, 32'h34);
    @(negedge clk);
    peek(3'h4, v); check("R4 new value on time", {24'b0, v[7:0]}, 32'h90);
  endtask

  task automatic t_write;
    logic [31:0] v; logic [7:0] b; int n;
    cmd(wr_word(7'd16, 8'h5A));
    peek(3'h0, v); check("R2 cmd readback", v, 32'h0001_105A);
    wait_idle(n); check("R3 busy length", n, WR_CYCLES);
    rd_byte(7'd16, b); check("R3 written byte", {24'b0, b}, 32'h5A);
  endtask

  task automatic t_readonly;
    logic [7:0] b; int n;
    cmd(wr_word(7'd0, 8'h77));
    wait_idle(n); check("R6 busy on ro write", n, WR_CYCLES);
    rd_byte(7'd0, b); check("R6 status unchanged", {24'b0, b}, 32'h00);
  endtask

  task automatic t_holes;
    logic [7:0] b; int n;
    cmd(wr_word(7'd5, 8'h33)); wait_idle(n);
    rd_byte(7'd5, b);  check("R7 addr5 reads zero", {24'b0, b}, 32'h00);
    rd_byte(7'd28, b); check("R7 addr28 reads zero", {24'b0, b}, 32'h00);
    rd_byte(7'd40, b); check("R7 addr40 reads zero", {24'b0, b}, 32'h00);
    cmd(wr_word(7'd1, 8'h55) | 32'h0000_8000); wait_idle(n);
    rd_byte(7'd1, b);  check("R7 reserved bit write discarded", {24'b0, b}, 32'hC3);
  endtask

  task automatic t_drop;
    logic [31:0] v; logic [7:0] b; int n;
    cmd(wr_word(7'd20, 8'hA1));
    cmd(wr_word(7'd21, 8'hB2));
    peek(3'h0, v); check("R8 cmd unchanged", v, 32'h0001_14A1);
    wait_idle(n); check("R8 original write finishes", n, 2);
    rd_byte(7'd20, b); check("R8 pending write landed", {24'b0, b}, 32'hA1);
    rd_byte(7'd21, b); check("R8 dropped write absent", {24'b0, b}, 32'h06);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    @(negedge clk); irq_in = 1'b1;
    peek(3'h4, v); check("R5 irq high", {31'b0, v[8]}, 32'h1);
    irq_in = 1'b0;
    peek(3'h4, v); check("R5 irq low", {31'b0, v[8]}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_read_latency;
    t_write;
    t_readonly;
    t_holes;
    t_drop;
    t_irq;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule